// File: doc/BRIEF.md
# Write-Protected Real-Time Clock Register File

This block is a real-time clock peripheral on a 32-bit register bus. A slow clock comes in as a level. It is synchronised into the bus clock, and its rising edges are divided down into a one-second step for a 32-bit seconds count. The block also holds an alarm compare word and a plain scratch word. A control/status word carries the enables, two sticky event flags and a write-ready indication. One interrupt line combines the two flags with their enables.

Every register write is guarded in two ways. First, software writes a key value to a separate unlock register. That opens the block for exactly one register write. Second, software must see the write-ready bit high. After each accepted write, write-ready stays low for a set number of slow-clock edges. The two event flags are sticky. Software clears a flag by writing 0 to its bit, and writing 1 to that bit leaves the flag as it is. This lets software rewrite the control word without losing an event it has not yet seen.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, seconds, alarm, scratch and unlock registers read 0, the control word reads 0x00000080 (only write-ready set), and `irq` is low.
- R2: Registers decode at byte offsets: control 0x00, seconds 0x04, alarm 0x08, scratch 0x34, unlock 0x3C. The scratch word stores any 32-bit value. Any other offset (for example 0x0C) reads 0.
- R3: Writing exactly 0x0000A55A to offset 0x3C sets the unlock state, which reads back as bit 31 of that register. Writing any other value leaves the unlock state unchanged. A register write made while locked changes nothing.
- R4: Each accepted register write clears the unlock state.
- R5: Control bit 7 is write-ready. It reads 0 from the accepted write until BUSY_TICKS rising slow-clock edges have passed. A register write made while it is 0 is ignored and does not consume the unlock. A key write is taken regardless of write-ready.
- R6: Control bits 5 (1 Hz interrupt enable), 3 (alarm interrupt enable), 2 (alarm enable) and 0 (counter enable) read back as written. Bit 1 reads 0.
- R7: While control bit 0 is set, seconds advance by one on every DIV-th rising slow-clock edge. While bit 0 is clear, seconds hold. Writing seconds loads the value and restarts the divider.
- R8: Control bit 6 (1 Hz flag) sets on every seconds increment.
- R9: Control bit 4 (alarm flag) sets when alarm enable is on and seconds become equal to the alarm word.
- R10: Writing 0 to bit 6 or bit 4 clears that flag, and writing 1 keeps it. A flag-setting event in the same cycle as a clearing write wins.
- R11: `irq` is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow timebase clock, sampled as a level |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The case of interest is a control write that clears the 1 Hz flag landing on the same bus cycle as a seconds increment. The bench provokes it by first stepping the divider to one edge short of wrapping. It then raises the slow clock and places the clearing write on the exact cycle in which the synchronised edge advances the counter. The write counts as correct if the seconds value has stepped and the flag still reads 1. A later clearing write, made with no increment in the same cycle, must then read 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_SECS  = 8'h04;
  localparam logic [7:0] OFF_ALARM = 8'h08;
  localparam logic [7:0] OFF_SCR   = 8'h34;
  localparam logic [7:0] OFF_KEY   = 8'h3C;

  localparam int B_READY  = 7;
  localparam int B_HZ_F   = 6;
  localparam int B_HZ_IE  = 5;
  localparam int B_AL_F   = 4;
  localparam int B_AL_IE  = 3;
  localparam int B_AL_EN  = 2;
  localparam int B_RUN    = 0;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A55A;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  logic [2:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[1:0], slow_clk};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // one bus-cycle pulse per rising slow-clock edge
  assign tick = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32,
  parameter int DIV   = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] secs,
  output logic             inc
);
  localparam int PW = $clog2(DIV + 1);

  logic [PW-1:0]    pre_q, pre_d;
  logic [CNT_W-1:0] sec_q, sec_d;
  logic             wrap;

  assign wrap = (pre_q == PW'(DIV - 1));
  assign inc  = run & tick & wrap & ~load;
  assign secs = sec_q;

  always_comb begin
    pre_d = pre_q;
    sec_d = sec_q;
    if (load) begin
      pre_d = '0;
      sec_d = load_val;
    end else if (run & tick) begin
      if (wrap) begin
        pre_d = '0;
        sec_d = sec_q + CNT_W'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
    end
  end

  // R7: without a load the count either holds or steps by one
  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + CNT_W'(1)));

  // R7: stopped counter holds
  a_r7_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_wrgate.sv
module rtc_wrgate #(
  parameter int          BUSY_TICKS = 2,
  parameter logic [31:0] KEY        = 32'h0000_A55A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        reg_wr,
  output logic        accept,
  output logic        unlocked,
  output logic        ready
);
  localparam int BW = $clog2(BUSY_TICKS + 2);

  logic          unl_q, unl_d;
  logic [BW-1:0] busy_q, busy_d;

  assign ready    = (busy_q == '0);
  assign unlocked = unl_q;
  assign accept   = reg_wr & unl_q & ready;

  always_comb begin
    unl_d  = unl_q;
    busy_d = busy_q;
    if (accept) begin
      unl_d  = 1'b0;
      busy_d = BW'(BUSY_TICKS);
    end else begin
      if (key_wr && key_data == KEY) unl_d = 1'b1;
      if (tick && busy_q != '0) busy_d = busy_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q  <= 1'b0;
      busy_q <= '0;
    end else begin
      unl_q  <= unl_d;
      busy_q <= busy_d;
    end
  end

  // R4: an accepted write relocks
  a_r4_relock: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !unl_q);

  // R3: only a key write opens the gate
  a_r3_stay_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && !key_wr) |=> !unl_q);

  if (BUSY_TICKS > 0) begin : g_busy_chk
    // R5: ready drops after an accepted write
    a_r5_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
  parameter int ADDR_W     = 8,
  parameter int DIV        = 32768,
  parameter int BUSY_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  import rtc_pkg::*;

  logic [1:0] rst_ff_q, rst_ff_d;
  logic       rst_s;

  always_comb rst_ff_d = {rst_ff_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff_q <= '0;
    else        rst_ff_q <= rst_ff_d;
  end
  assign rst_s = rst_ff_q[1];

  logic hit_ctrl, hit_secs, hit_alarm, hit_scr, hit_key;
  assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_secs  = (bus_addr == ADDR_W'(OFF_SECS));
  assign hit_alarm = (bus_addr == ADDR_W'(OFF_ALARM));
  assign hit_scr   = (bus_addr == ADDR_W'(OFF_SCR));
  assign hit_key   = (bus_addr == ADDR_W'(OFF_KEY));

  logic tick, accept, unlocked, ready, reg_wr, key_wr, inc;
  logic [31:0] secs;

  assign reg_wr = bus_we & (hit_ctrl | hit_secs | hit_alarm | hit_scr);
  assign key_wr = bus_we & hit_key;

  rtc_tick_sync u_sync (
    .clk(clk), .rst_n(rst_s), .slow_clk(slow_clk), .tick(tick)
  );

  rtc_wrgate #(.BUSY_TICKS(BUSY_TICKS), .KEY(UNLOCK_KEY)) u_gate (
    .clk(clk), .rst_n(rst_s), .tick(tick), .key_wr(key_wr),
    .key_data(bus_wdata), .reg_wr(reg_wr), .accept(accept),
    .unlocked(unlocked), .ready(ready)
  );

  logic run_q, run_d, ae_q, ae_d, aie_q, aie_d, hie_q, hie_d;
  logic hf_q, hf_d, af_q, af_d, match_q, match_d;
  logic [31:0] alarm_q, alarm_d, scr_q, scr_d;
  logic wr_ctrl, alarm_set;

  assign wr_ctrl = accept & hit_ctrl;

  rtc_counter #(.CNT_W(32), .DIV(DIV)) u_cnt (
    .clk(clk), .rst_n(rst_s), .tick(tick), .run(run_q),
    .load(accept & hit_secs), .load_val(bus_wdata), .secs(secs), .inc(inc)
  );

  assign match_d   = ae_q & (secs == alarm_q);
  assign alarm_set = match_d & ~match_q;

  always_comb begin
    run_d = run_q;  ae_d = ae_q;  aie_d = aie_q;  hie_d = hie_q;
    hf_d  = hf_q;   af_d = af_q;
    alarm_d = alarm_q;
    scr_d   = scr_q;
    if (wr_ctrl) begin
      run_d = bus_wdata[B_RUN];
      ae_d  = bus_wdata[B_AL_EN];
      aie_d = bus_wdata[B_AL_IE];
      hie_d = bus_wdata[B_HZ_IE];
      hf_d  = hf_q & bus_wdata[B_HZ_F];
      af_d  = af_q & bus_wdata[B_AL_F];
    end
    if (accept & hit_alarm) alarm_d = bus_wdata;
    if (accept & hit_scr)   scr_d   = bus_wdata;
    if (inc)       hf_d = 1'b1;
    if (alarm_set) af_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      run_q <= 1'b0; ae_q <= 1'b0; aie_q <= 1'b0; hie_q <= 1'b0;
      hf_q  <= 1'b0; af_q <= 1'b0; match_q <= 1'b0;
      alarm_q <= '0; scr_q <= '0;
    end else begin
      run_q <= run_d; ae_q <= ae_d; aie_q <= aie_d; hie_q <= hie_d;
      hf_q  <= hf_d;  af_q <= af_d; match_q <= match_d;
      alarm_q <= alarm_d; scr_q <= scr_d;
    end
  end

  logic [31:0] ctrl_word;
  always_comb begin
    ctrl_word          = '0;
    ctrl_word[B_READY] = ready;
    ctrl_word[B_HZ_F]  = hf_q;
    ctrl_word[B_HZ_IE] = hie_q;
    ctrl_word[B_AL_F]  = af_q;
    ctrl_word[B_AL_IE] = aie_q;
    ctrl_word[B_AL_EN] = ae_q;
    ctrl_word[B_RUN]   = run_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)  bus_rdata = ctrl_word;
    if (hit_secs)  bus_rdata = secs;
    if (hit_alarm) bus_rdata = alarm_q;
    if (hit_scr)   bus_rdata = scr_q;
    if (hit_key)   bus_rdata = {unlocked, 31'b0};
  end

  assign irq = (hf_q & hie_q) | (af_q & aie_q);

  // R8: every increment leaves the 1 Hz flag set
  a_r8_flag_on_step: assert property (@(posedge clk) disable iff (!rst_s)
    inc |=> hf_q);

  // R9: an alarm match leaves the alarm flag set
  a_r9_flag_on_match: assert property (@(posedge clk) disable iff (!rst_s)
    alarm_set |=> af_q);

  // R10: a set flag survives any cycle without a control write
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_s)
    (hf_q && !wr_ctrl) |=> hf_q);
endmodule

// File: tb/test_rtc_regfile.sv
module test_rtc_regfile;
  localparam int DIV  = 4;
  localparam int BUSY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_regfile #(.ADDR_W(8), .DIV(DIV), .BUSY_TICKS(BUSY)) i_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic slow_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) slow_clk = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic wait_ready();
    logic [31:0] c;
    for (int i = 0; i < 20; i++) begin
      rd(8'h00, c);
      if (c[7]) break;
      slow_edges(1);
    end
  endtask

  task automatic pwr(input logic [7:0] a, input logic [31:0] d);
    wait_ready();
    wr(8'h3C, 32'h0000_A55A);
    wr(a, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 ctrl", v, 32'h80);
    rd(8'h04, v); check("R1 secs", v, 0);
    rd(8'h08, v); check("R1 alarm", v, 0);
    rd(8'h34, v); check("R1 scratch", v, 0);
    rd(8'h3C, v); check("R1 unlock", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(8'h3C, 32'h0000_1234);
    rd(8'h3C, v); check("R3 wrong key", v, 0);
    wr(8'h34, 32'hDEAD_BEEF);
    rd(8'h34, v); check("R3 locked write", v, 0);
    wr(8'h3C, 32'h0000_A55A);
    rd(8'h3C, v); check("R3 key opens", v, 32'h8000_0000);
    wr(8'h34, 32'hDEAD_BEEF);
    rd(8'h34, v); check("R2 scratch", v, 32'hDEAD_BEEF);
    rd(8'h3C, v); check("R4 relock", v, 0);
    rd(8'h00, v); check("R5 ready low", v, 32'h00);
  endtask

  task automatic t_busy();
    logic [31:0] v;
    wr(8'h3C, 32'h0000_A55A);
    wr(8'h34, 32'h0000_1111);
    rd(8'h34, v); check("R5 busy write ignored", v, 32'hDEAD_BEEF);
    rd(8'h3C, v); check("R5 unlock kept", v, 32'h8000_0000);
    slow_edges(1);
    rd(8'h00, v); check("R5 still busy", v, 32'h00);
    slow_edges(1);
    rd(8'h00, v); check("R5 ready back", v, 32'h80);
    wr(8'h34, 32'h0000_1111);
    rd(8'h34, v); check("R2 scratch 2", v, 32'h0000_1111);
    rd(8'h0C, v); check("R2 unmapped", v, 0);
  endtask

  task automatic t_ctrl_bits();
    logic [31:0] v;
    pwr(8'h00, 32'h0000_002A);
    rd(8'h00, v); check("R6 ie bits", v, 32'h28);
    check("R11 no flags", {31'b0, irq}, 0);
    pwr(8'h00, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    pwr(8'h04, 32'd100);
    wait_ready();
    slow_edges(4);
    rd(8'h04, v); check("R7 hold when stopped", v, 100);
    pwr(8'h00, 32'h1);
    slow_edges(4);
    rd(8'h04, v); check("R7 step", v, 101);
    rd(8'h00, v); check("R8 hz flag", v, 32'hC1);
    slow_edges(3);
    rd(8'h04, v); check("R7 no early step", v, 101);
    slow_edges(1);
    rd(8'h04, v); check("R7 second step", v, 102);
  endtask

  task automatic t_alarm();
    logic [31:0] v;
    pwr(8'h00, 32'h0);
    pwr(8'h08, 32'd105);
    pwr(8'h04, 32'd104);
    pwr(8'h00, 32'h0D);
    rd(8'h00, v); check("R9 no early alarm", v & 32'h10, 0);
    check("R11 irq low", {31'b0, irq}, 0);
    slow_edges(4);
    rd(8'h04, v); check("R7 to alarm", v, 105);
    rd(8'h00, v); check("R9 alarm flag", v, 32'hDD);
    check("R11 alarm irq", {31'b0, irq}, 1);
    pwr(8'h00, 32'h4D);
    rd(8'h00, v); check("R10 clear alarm keep hz", v, 32'h4D);
    check("R11 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    pwr(8'h04, 32'd200);
    slow_edges(3);
    rd(8'h04, v); check("R7 loaded", v, 200);
    wr(8'h3C, 32'h0000_A55A);
    @(negedge clk) slow_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h0D; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    @(negedge clk) slow_clk = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h04, v); check("R7 step in race", v, 201);
    rd(8'h00, v); check("R10 set wins over clear", v & 32'h40, 32'h40);
  endtask

  task automatic t_hz_irq();
    logic [31:0] v;
    pwr(8'h00, 32'h61);
    check("R11 hz irq", {31'b0, irq}, 1);
    pwr(8'h00, 32'h21);
    rd(8'h00, v); check("R10 clear hz", v & 32'h40, 0);
    check("R11 hz irq off", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unlock();
    t_busy();
    t_ctrl_bits();
    t_count();
    t_alarm();
    t_race();
    t_hz_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule